// File: doc/BRIEF.md
# Memory-Mapped Event Timer Core

This block is the shared heart of a high-resolution event timer. It holds one free-running up counter, a read-only capability word, a global configuration word and a per-channel pending-interrupt word. It sits behind a plain 64-bit register bus with a byte address, a write enable, write data, byte strobes and combinational read data. The bus also reaches three comparator channels, whose register windows it decodes and whose read data it returns.

The channels are outside this block. They receive the counter value, a global enable and a legacy-routing select. Each raises a one-cycle event pulse when it fires. The core records each event as a pending flag. It drives one interrupt line per channel, gated by the global enable. When legacy routing is on, channel 0 is steered to a periodic-tick line and channel 1 to a real-time-clock line.

Software reads the capability word to learn the tick period and the channel count. It loads the counter while the timer is stopped, sets the enable bit, and acknowledges interrupts by writing ones to the pending word.

Top module: `mmt_core`

## Requirements
- R1: After reset, the counter, the configuration word, the pending word, every interrupt output, `glb_en` and `legacy_sel` are all zero.
- R2: The word at offset 0x000 is read-only and reads as follows:
  - bits 63:32 hold the tick period in femtoseconds (default 0x00989680);
  - bits 31:16 hold the vendor code (default 0x1D0C);
  - bit 15 is 1 (legacy routing supported);
  - bit 14 is 0;
  - bit 13 is 1 when the counter is 64 bits wide;
  - bits 12:8 hold the channel count minus one;
  - bits 7:0 hold the revision (default 0x01).
  Writes to this word leave it unchanged.
- R3: The configuration word at 0x010 stores the run enable in bit 0 and the legacy-routing select in bit 1. It is written only when strobe bit 0 is set. Its other bits read as zero. Bit 0 drives `glb_en` and bit 1 drives `legacy_sel`.
- R4: While the run enable is 1, the counter rises by exactly one per clock. While it is 0, the counter holds its value.
- R5: The counter can be read and written at 0x0F0. A write replaces only the bytes whose strobes are set. A write always takes effect, even while the counter is running, and counting resumes from the new value on the following clock.
- R6: The pending word at 0x020 holds bit N for channel N.
  - An event pulse on channel N sets bit N only while the run enable is 1. Events that arrive while it is 0 are ignored.
  - Writing a 1 to bit N with strobe bit 0 set clears that bit. Writing a 0 has no effect.
- R7: If a channel event and a clear of the same pending bit fall in one cycle, the bit ends up set.
- R8: `irq_line[N]` is high exactly when bit N is pending, the run enable is 1, and the channel is not steered to a legacy line. With the run enable at 0, every interrupt output is low.
- R9: With legacy routing on, the following hold:
  - `irq_line[0]` and `irq_line[1]` stay low;
  - `legacy_pit_irq` follows channel 0's pending flag under the run enable;
  - `legacy_rtc_irq` follows channel 1's pending flag under the run enable;
  - channel 2 keeps its own line.
- R10: Each channel N has a 32-byte window at 0x100+0x20*N. A bus address inside that window produces the following:
  - `ch_sel` is one-hot on bit N;
  - `ch_word` gives the slot: 0 for config at +0x00, 1 for the comparator at +0x08, 2 for the route at +0x10;
  - `ch_we` mirrors `ch_sel` during a write;
  - the read data is that channel's `ch_rdata` slice.
- R11: The following addresses select nothing, read as zero and ignore writes, and for them `ch_word` is 3:
  - offsets with no register;
  - the reserved slot +0x18 of a channel window;
  - windows beyond the last channel;
  - any address whose low three bits are nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 64 | Write data |
| bus_be | input | 8 | Byte strobes for writes |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| cnt_value | output | 64 | Current counter value, zero-extended |
| glb_en | output | 1 | Global run enable to the channels |
| legacy_sel | output | 1 | Legacy-routing select to the channels |
| ch_sel | output | NUM_CH | One-hot select of the addressed channel |
| ch_word | output | 2 | Slot within the channel window, 3 when none |
| ch_we | output | NUM_CH | Write strobe to the addressed channel |
| ch_rdata | input | NUM_CH*64 | Read data from each channel, channel 0 lowest |
| ch_event | input | NUM_CH | One-cycle event pulse from each channel |
| irq_line | output | NUM_CH | Per-channel interrupt request |
| legacy_pit_irq | output | 1 | Periodic-tick interrupt in legacy mode |
| legacy_rtc_irq | output | 1 | Real-time-clock interrupt in legacy mode |

## Verification
Most of the state is one register away from a port. A pending flag that was set or cleared wrongly shows on `irq_line`, or on the legacy lines, one clock after the event or the write. It also shows in a read of 0x020 in that same cycle. A counter that misses a step, or runs while halted, differs from the expected value on `cnt_value` one clock after the fault and stays off by that amount. Decode faults are combinational, so they appear in `ch_sel`, `ch_word` and `bus_rdata` in the same cycle as the address.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 64;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [ADDR_W-1:0] OFS_CAP = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CFG = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_STS = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_CNT = 12'h0F0;
    // channel windows start at 0x100, expressed in 8-byte words
    localparam logic [ADDR_W-4:0] CH_BASE_WORD = 9'h020;

    typedef enum logic [1:0] {
        WIN_CFG   = 2'd0,
        WIN_CMP   = 2'd1,
        WIN_ROUTE = 2'd2,
        WIN_NONE  = 2'd3
    } ch_word_e;

    typedef struct packed {
        logic     cap;
        logic     cfg;
        logic     sts;
        logic     cnt;
        logic     ch_any;
        logic [6:0] ch_idx;
        ch_word_e word;
    } bus_dec_t;

    typedef struct packed {
        logic legacy;
        logic run;
    } glb_cfg_t;

    function automatic logic [DATA_W-1:0] byte_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [BE_W-1:0]   be
    );
        logic [DATA_W-1:0] r;
        for (int b = 0; b < BE_W; b++) begin
            r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] make_cap(
        input logic [31:0] tick_fs,
        input logic [15:0] vendor,
        input logic        wide_ok,
        input logic [4:0]  last_ch,
        input logic [7:0]  rev
    );
        return {tick_fs, vendor, 1'b1, 1'b0, wide_ok, last_ch, rev};
    endfunction

endpackage

// File: rtl/mmt_decode.sv
module mmt_decode
    import mmt_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output bus_dec_t          dec
);
    logic [ADDR_W-4:0] rel;

    always_comb begin
        dec      = '0;
        dec.word = WIN_NONE;
        rel      = addr[ADDR_W-1:3] - CH_BASE_WORD;
        if (addr[2:0] == 3'b000) begin
            case (addr)
                OFS_CAP: dec.cap = 1'b1;
                OFS_CFG: dec.cfg = 1'b1;
                OFS_STS: dec.sts = 1'b1;
                OFS_CNT: dec.cnt = 1'b1;
                default: begin
                    if (addr[ADDR_W-1:3] >= CH_BASE_WORD
                        && 32'(rel[ADDR_W-4:2]) < NUM_CH
                        && rel[1:0] != 2'd3) begin
                        dec.ch_any = 1'b1;
                        dec.ch_idx = rel[ADDR_W-4:2];
                        dec.word   = ch_word_e'(rel[1:0]);
                    end
                end
            endcase
        end
    end

    // R10, R11: at most one target is selected for any address
    always_comb begin
        assert_one_target_R10: assert ($onehot0({dec.cap, dec.cfg, dec.sts, dec.cnt, dec.ch_any}));
    end

endmodule

// File: rtl/mmt_counter.sv
module mmt_counter
    import mmt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] merged;

    assign merged = byte_merge(DATA_W'(count), wdata, be);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_en) begin
            count <= merged[CNT_W-1:0];
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_en) |=> $stable(count));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !wr_en) |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && be == '1) |=> (count == $past(wdata[CNT_W-1:0])));

endmodule

// File: rtl/mmt_irq.sv
module mmt_irq #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              legacy,
    input  logic [NUM_CH-1:0] evt,
    input  logic              clr_en,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] pending,
    output logic [NUM_CH-1:0] irq_line,
    output logic              pit_irq,
    output logic              rtc_irq
);
    logic [NUM_CH-1:0] kill;
    logic [NUM_CH-1:0] setv;

    assign kill = clr_en ? clr_mask : '0;
    assign setv = run ? evt : '0;

    // set beats clear when both hit one bit
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else begin
            pending <= (pending & ~kill) | setv;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_line
        if (i < 2) begin : g_steer
            assign irq_line[i] = run & pending[i] & ~legacy;
        end else begin : g_plain
            assign irq_line[i] = run & pending[i];
        end
    end

    assign pit_irq = run & legacy & pending[0];
    assign rtc_irq = run & legacy & pending[1];

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (run && (evt != '0)) |=> ((pending & $past(evt)) == $past(evt)));

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !run) |=> ((pending & $past(clr_mask)) == '0));

    assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !run |-> (irq_line == '0 && !pit_irq && !rtc_irq));

    assert_halt_no_set_R6: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr_en) |=> $stable(pending));

endmodule

// File: rtl/mmt_core.sv
module mmt_core
    import mmt_pkg::*;
#(
    parameter int          NUM_CH    = 3,
    parameter int          CNT_W     = 64,
    parameter logic [31:0] TICK_FS   = 32'h0098_9680,
    parameter logic [15:0] VENDOR_ID = 16'h1D0C,
    parameter logic [7:0]  REV_ID    = 8'h01
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [11:0]              bus_addr,
    input  logic                     bus_we,
    input  logic [63:0]              bus_wdata,
    input  logic [7:0]               bus_be,
    output logic [63:0]              bus_rdata,
    output logic [63:0]              cnt_value,
    output logic                     glb_en,
    output logic                     legacy_sel,
    output logic [NUM_CH-1:0]        ch_sel,
    output logic [1:0]               ch_word,
    output logic [NUM_CH-1:0]        ch_we,
    input  logic [NUM_CH*64-1:0]     ch_rdata,
    input  logic [NUM_CH-1:0]        ch_event,
    output logic [NUM_CH-1:0]        irq_line,
    output logic                     legacy_pit_irq,
    output logic                     legacy_rtc_irq
);
    localparam logic [DATA_W-1:0] CAP_WORD =
        make_cap(TICK_FS, VENDOR_ID, (CNT_W == 64), 5'(NUM_CH - 1), REV_ID);

    bus_dec_t          dec;
    glb_cfg_t          cfg_q;
    logic [CNT_W-1:0]  count;
    logic [NUM_CH-1:0] pending;
    logic              cfg_wr;
    logic              cnt_wr;
    logic              sts_clr;

    mmt_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign cfg_wr  = bus_we && dec.cfg && bus_be[0];
    assign cnt_wr  = bus_we && dec.cnt;
    assign sts_clr = bus_we && dec.sts && bus_be[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= glb_cfg_t'(bus_wdata[1:0]);
        end
    end

    assign glb_en     = cfg_q.run;
    assign legacy_sel = cfg_q.legacy;

    mmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (cfg_q.run),
        .wr_en (cnt_wr),
        .wdata (bus_wdata),
        .be    (bus_be),
        .count (count)
    );

    assign cnt_value = 64'(count);

    mmt_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .run      (cfg_q.run),
        .legacy   (cfg_q.legacy),
        .evt      (ch_event),
        .clr_en   (sts_clr),
        .clr_mask (bus_wdata[NUM_CH-1:0]),
        .pending  (pending),
        .irq_line (irq_line),
        .pit_irq  (legacy_pit_irq),
        .rtc_irq  (legacy_rtc_irq)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chsel
        assign ch_sel[i] = dec.ch_any && (32'(dec.ch_idx) == i);
        assign ch_we[i]  = ch_sel[i] && bus_we;
    end

    assign ch_word = dec.word;

    always_comb begin
        bus_rdata = '0;
        if (dec.cap) bus_rdata = CAP_WORD;
        if (dec.cfg) bus_rdata = 64'(cfg_q);
        if (dec.sts) bus_rdata = 64'(pending);
        if (dec.cnt) bus_rdata = 64'(count);
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel[i]) bus_rdata = ch_rdata[i*64 +: 64];
        end
    end

    assert_cfg_write_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (glb_en == $past(bus_wdata[0]) && legacy_sel == $past(bus_wdata[1])));

    assert_legacy_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        legacy_sel |-> (irq_line[1:0] == 2'b00));

    assert_we_follows_sel_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_we |-> (ch_we == '0));

endmodule

// File: tb/test_mmt_core.sv
module test_mmt_core;

    localparam int NCH = 3;
    localparam logic [11:0] A_CAP = 12'h000;
    localparam logic [11:0] A_CFG = 12'h010;
    localparam logic [11:0] A_STS = 12'h020;
    localparam logic [11:0] A_CNT = 12'h0F0;
    localparam logic [63:0] CAP_EXP = 64'h0098_9680_1D0C_A201;

    localparam int K_RD  = 0;
    localparam int K_CNT = 1;
    localparam int K_IRQ = 2;
    localparam int K_CHS = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [11:0]       bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [63:0]       bus_wdata = '0;
    logic [7:0]        bus_be = '0;
    logic [63:0]       bus_rdata;
    logic [63:0]       cnt_value;
    logic              glb_en;
    logic              legacy_sel;
    logic [NCH-1:0]    ch_sel;
    logic [1:0]        ch_word;
    logic [NCH-1:0]    ch_we;
    logic [NCH*64-1:0] ch_rdata;
    logic [NCH-1:0]    ch_event = '0;
    logic [NCH-1:0]    irq_line;
    logic              legacy_pit_irq;
    logic              legacy_rtc_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct {
        int          kind;
        logic [63:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    // channel model: each channel answers with a tag of its index and slot
    for (genvar n = 0; n < NCH; n++) begin : g_chm
        assign ch_rdata[n*64 +: 64] = 64'hA5A5_0000_0000_0000 | (64'(n) << 8) | 64'(ch_word);
    end

    mmt_core i_mmt_core (
        .clk            (clk),
        .rst            (rst),
        .bus_addr       (bus_addr),
        .bus_we         (bus_we),
        .bus_wdata      (bus_wdata),
        .bus_be         (bus_be),
        .bus_rdata      (bus_rdata),
        .cnt_value      (cnt_value),
        .glb_en         (glb_en),
        .legacy_sel     (legacy_sel),
        .ch_sel         (ch_sel),
        .ch_word        (ch_word),
        .ch_we          (ch_we),
        .ch_rdata       (ch_rdata),
        .ch_event       (ch_event),
        .irq_line       (irq_line),
        .legacy_pit_irq (legacy_pit_irq),
        .legacy_rtc_irq (legacy_rtc_irq)
    );

    // monitor: compares queued expectations mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [63:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_CNT:   act = cnt_value;
                    K_IRQ:   act = {59'd0, legacy_rtc_irq, legacy_pit_irq, irq_line};
                    default: act = {56'd0, ch_we, ch_sel, ch_word};
                endcase
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic chk(input int kind, input logic [11:0] a, input logic we,
                       input logic [63:0] e, input string tag);
        bus_addr = a;
        bus_we   = we;
        sb_q.push_back('{kind: kind, exp: e, tag: tag});
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [7:0] be);
        bus_addr  = a;
        bus_wdata = d;
        bus_be    = be;
        bus_we    = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
        bus_be = '0;
    endtask

    task automatic pulse(input logic [NCH-1:0] e);
        ch_event = e;
        @(posedge clk); #1;
        ch_event = '0;
    endtask

    task automatic pulse_and_clear(input logic [NCH-1:0] e, input logic [63:0] mask);
        ch_event  = e;
        bus_addr  = A_STS;
        bus_wdata = mask;
        bus_be    = 8'h01;
        bus_we    = 1'b1;
        @(posedge clk); #1;
        ch_event = '0;
        bus_we   = 1'b0;
        bus_be   = '0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk(K_RD,  A_CFG, 0, 64'h0, "R1 config after reset");
        chk(K_RD,  A_STS, 0, 64'h0, "R1 pending after reset");
        chk(K_CNT, A_CAP, 0, 64'h0, "R1 counter after reset");
        chk(K_IRQ, A_CAP, 0, 64'h0, "R1 interrupts after reset");

        // R2 capability word, read-only
        chk(K_RD, A_CAP, 0, CAP_EXP, "R2 capability layout");
        wr(A_CAP, '1, 8'hFF);
        chk(K_RD, A_CAP, 0, CAP_EXP, "R2 capability ignores write");

        // R3 configuration bits and strobe
        wr(A_CFG, 64'hFFFF_FFFF_FFFF_FFFE, 8'hFF);
        chk(K_RD, A_CFG, 0, 64'h2, "R3 legacy bit only, reserved zero");
        wr(A_CFG, 64'h1, 8'hFE);
        chk(K_RD, A_CFG, 0, 64'h2, "R3 write without strobe 0 ignored");
        wr(A_CFG, 64'h0, 8'h01);
        chk(K_RD, A_CFG, 0, 64'h0, "R3 cleared");

        // R4 hold while halted, R5 load and byte strobes
        wr(A_CNT, 64'h1122_3344_5566_7788, 8'hFF);
        chk(K_CNT, A_CAP, 0, 64'h1122_3344_5566_7788, "R5 counter load");
        chk(K_CNT, A_CAP, 0, 64'h1122_3344_5566_7788, "R4 counter holds when halted");
        wr(A_CNT, 64'hAAAA_AAAA_AAAA_AAAA, 8'h0F);
        chk(K_RD, A_CNT, 0, 64'h1122_3344_AAAA_AAAA, "R5 partial strobe write");

        // R11 reserved and misaligned addresses
        wr(12'h030, '1, 8'hFF);
        chk(K_RD, 12'h030, 0, 64'h0, "R11 reserved offset reads zero");
        chk(K_RD, 12'h0F4, 0, 64'h0, "R11 misaligned counter address reads zero");
        wr(12'h014, 64'h3, 8'hFF);
        chk(K_RD, A_CFG, 0, 64'h0, "R11 misaligned write no effect");

        // R4/R5 counting and write while running
        wr(A_CFG, 64'h1, 8'h01);
        wr(A_CNT, 64'h100, 8'hFF);
        chk(K_CNT, A_CAP, 0, 64'h100, "R5 write wins while running");
        chk(K_CNT, A_CAP, 0, 64'h101, "R4 count step 1");
        chk(K_CNT, A_CAP, 0, 64'h102, "R4 count step 2");
        wr(A_CFG, 64'h0, 8'h01);
        chk(K_CNT, A_CAP, 0, 64'h104, "R4 stops after disable");
        chk(K_CNT, A_CAP, 0, 64'h104, "R4 stays stopped");

        // R6 events ignored while halted
        pulse(3'b001);
        chk(K_RD,  A_STS, 0, 64'h0, "R6 event while halted ignored");
        chk(K_IRQ, A_CAP, 0, 64'h0, "R8 no interrupt while halted");

        // R6/R8 events while running
        wr(A_CFG, 64'h1, 8'h01);
        pulse(3'b101);
        chk(K_RD,  A_STS, 0, 64'h5, "R6 events set pending");
        chk(K_IRQ, A_CAP, 0, 64'h5, "R8 lines follow pending");
        wr(A_STS, 64'h4, 8'h01);
        chk(K_RD, A_STS, 0, 64'h1, "R6 write one clears");
        wr(A_STS, 64'h0, 8'h01);
        chk(K_RD, A_STS, 0, 64'h1, "R6 write zero no effect");
        wr(A_STS, 64'h1, 8'h00);
        chk(K_RD, A_STS, 0, 64'h1, "R6 clear needs strobe 0");

        // R8 gating by the run enable
        wr(A_CFG, 64'h0, 8'h01);
        chk(K_IRQ, A_CAP, 0, 64'h0, "R8 disable gates lines");
        chk(K_RD,  A_STS, 0, 64'h1, "R8 pending kept while gated");

        // R9 legacy steering
        wr(A_CFG, 64'h3, 8'h01);
        pulse(3'b010);
        chk(K_IRQ, A_CAP, 0, 64'h18, "R9 channels 0 and 1 on legacy lines");
        pulse(3'b100);
        chk(K_IRQ, A_CAP, 0, 64'h1C, "R9 channel 2 keeps its line");

        // R7 event and clear in one cycle
        wr(A_STS, 64'h7, 8'h01);
        chk(K_RD, A_STS, 0, 64'h0, "R6 clear all");
        pulse_and_clear(3'b001, 64'h5);
        chk(K_RD, A_STS, 0, 64'h1, "R7 event beats clear");
        pulse(3'b100);
        pulse_and_clear(3'b001, 64'h5);
        chk(K_RD, A_STS, 0, 64'h1, "R7 other bit still cleared");

        // R10/R11 channel decode, {we,sel,word}
        chk(K_CHS, 12'h128, 1, 64'h49, "R10 ch1 comparator write");
        chk(K_CHS, 12'h150, 0, 64'h12, "R10 ch2 route read");
        chk(K_CHS, 12'h100, 0, 64'h04, "R10 ch0 config");
        chk(K_CHS, 12'h118, 1, 64'h03, "R11 reserved slot selects nothing");
        chk(K_CHS, 12'h160, 1, 64'h03, "R11 beyond last channel");
        chk(K_RD,  12'h108, 0, 64'hA5A5_0000_0000_0001, "R10 ch0 comparator data");
        chk(K_RD,  12'h150, 0, 64'hA5A5_0000_0000_0202, "R10 ch2 route data");
        chk(K_RD,  12'h160, 0, 64'h0, "R11 beyond last channel reads zero");

        @(negedge clk);
        @(posedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule